// File: doc/BRIEF.md
# Dot-Matrix LCD Scan Timing Generator

This block turns a free-running dot clock into the column and row scan timing for a dot-matrix LCD panel that is driven as an upper half and a lower half. Each display line is built from a programmable number of 4-bit nibbles. Every nibble gets two dot-clock cycles. In the first cycle the block asks the upstream stream for data. In the second cycle it raises the shift clock while the captured nibble sits on the panel bus. After the last nibble comes a one-cycle line latch pulse.

A row counter walks through the programmed number of lines per half, which is also the multiplexing duty. The first-line marker rises during the latch pulse of row 0. The AC-inversion output flips at that same edge, once per frame. A mode input chooses dual-screen operation, where the upper and lower buses are fed in parallel, or single-screen operation, where only the upper bus carries pixels. A display-enable input blanks both buses without disturbing the timing.

The upstream source presents nibbles on a combinational stream. The block takes a nibble at every clock edge where its request output is high. The configuration comes in on ports, so the active-low reset clears only the counters and the data registers.

Top module: `lcd_scan_gen`

## Requirements
- R1: With N = cfg_nibbles (a value of 0 counts as 1), each line lasts 2N+1 dot clocks. The shift clock is high for exactly one cycle in the 2nd, 4th, ... 2N-th cycle of the line, and low in the cycles between.
- R2: The latch clock is high for exactly the one cycle that directly follows the last shift pulse of a line. The shift clock is low during that cycle.
- R3: Rows count 0 to R-1 and then wrap, with R = cfg_rows (0 counts as 1). The first-line marker is high only during the latch cycle of row 0.
- R4: ac_out is 0 after reset. It inverts at the same clock edge at which the first-line marker rises, and holds its value at every other edge.
- R5: pix_req is high in the cycle before each shift pulse. The pix_up value accepted at that edge is on lu for the whole shift-pulse cycle.
- R6: In dual mode (dual_mode=1), ld carries the accepted pix_dn nibble with the same timing as lu. In single mode (dual_mode=0), ld is always 0.
- R7: While disp_en is 0, both lu and ld are 0. Shift, latch, first-line marker and AC timing are unchanged.
- R8: While rst_n is low, shift_clk, latch_clk, flm, ac_out, lu and ld are all 0, without waiting for a clock edge. After release, the scan begins at the first nibble of row 0.
- R9: With R = 1 (static drive), the first-line marker goes high on every latch pulse and ac_out inverts once per line.
- R10: A cfg_nibbles or cfg_rows value of 0 behaves exactly like a value of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset of counters and data registers |
| cfg_nibbles | input | NIB_W | Nibbles per line (line width in dots / 4) |
| cfg_rows | input | ROW_W | Lines per half, equal to the multiplexing duty denominator |
| dual_mode | input | 1 | 1: dual screen, 0: single screen |
| disp_en | input | 1 | 0 blanks both data buses |
| pix_up | input | DATA_W | Upstream nibble for the upper half |
| pix_dn | input | DATA_W | Upstream nibble for the lower half |
| pix_req | output | 1 | High when a nibble is accepted at the next edge |
| shift_clk | output | 1 | Column shift strobe, one pulse per nibble |
| latch_clk | output | 1 | Line latch pulse |
| flm | output | 1 | First-line marker |
| ac_out | output | 1 | AC-inversion signal |
| lu | output | DATA_W | Upper-half nibble bus |
| ld | output | DATA_W | Lower-half nibble bus |

## Verification
The state changes at every dot-clock edge, so all timing outputs for the k-th edge after reset release are sampled at the falling edge that follows it. They are compared with a reference that places cycle k at position k mod (2N+1) within the line and at row (k div (2N+1)) mod R. A nibble driven after edge k is captured at edge k+1 and is due on the bus at that same sample, while the shift pulse is high. The blanking and single-mode masks act in the same cycle their input changes. Reset acts before any edge, so its effect is sampled one time step after rst_n falls.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  // Position of the scan sequencer inside one line.
  typedef enum logic [1:0] {
    PH_LOAD  = 2'd0,  // nibble requested and captured at the edge
    PH_SHIFT = 2'd1,  // shift strobe high, nibble on the bus
    PH_LATCH = 2'd2   // line latch pulse
  } scan_phase_e;

  // A programmed count of zero is treated as one.
  function automatic int unsigned eff_count(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  // Dot clocks per display line for a given nibble count.
  function automatic int unsigned line_period(input int unsigned nibbles);
    return 2 * eff_count(nibbles) + 1;
  endfunction

endpackage

// File: rtl/lcd_col_seq.sv
module lcd_col_seq
  import lcd_scan_pkg::*;
#(
  parameter int NIB_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIB_W-1:0] cfg_nibbles,
  output scan_phase_e      phase_o,
  output logic             line_last_o,
  output logic             line_end_o
);

  scan_phase_e      phase_q;
  logic [NIB_W-1:0] col_q;
  logic [NIB_W-1:0] last_col;

  assign last_col = NIB_W'(eff_count(32'(cfg_nibbles)) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_LOAD;
      col_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_LOAD:  phase_q <= PH_SHIFT;
        PH_SHIFT: begin
          if (col_q >= last_col) begin
            phase_q <= PH_LATCH;
          end else begin
            phase_q <= PH_LOAD;
            col_q   <= col_q + 1'b1;
          end
        end
        PH_LATCH: begin
          phase_q <= PH_LOAD;
          col_q   <= '0;
        end
        default: begin
          phase_q <= PH_LOAD;
          col_q   <= '0;
        end
      endcase
    end
  end

  assign phase_o     = phase_q;
  assign line_last_o = (phase_q == PH_SHIFT) && (col_q >= last_col);
  assign line_end_o  = (phase_q == PH_LATCH);

endmodule

// File: rtl/lcd_row_seq.sv
module lcd_row_seq
  import lcd_scan_pkg::*;
#(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] cfg_rows,
  input  logic             line_last,
  input  logic             line_end,
  output logic [ROW_W-1:0] row_o,
  output logic             first_row_o,
  output logic             frame_start_o,
  output logic             ac_o
);

  logic [ROW_W-1:0] row_q;
  logic [ROW_W-1:0] last_row;
  logic             ac_q;

  assign last_row = ROW_W'(eff_count(32'(cfg_rows)) - 1);

  // Look-ahead: the next edge enters the latch cycle of row 0.
  assign frame_start_o = line_last && (row_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      ac_q  <= 1'b0;
    end else begin
      if (line_end) begin
        row_q <= (row_q >= last_row) ? '0 : row_q + 1'b1;
      end
      if (frame_start_o) begin
        ac_q <= ~ac_q;
      end
    end
  end

  assign row_o       = row_q;
  assign first_row_o = (row_q == '0);
  assign ac_o        = ac_q;

endmodule

// File: rtl/lcd_nib_path.sv
module lcd_nib_path #(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [DATA_W-1:0] up_in,
  input  logic [DATA_W-1:0] dn_in,
  input  logic              dual_mode,
  input  logic              disp_en,
  output logic [DATA_W-1:0] up_o,
  output logic [DATA_W-1:0] dn_o
);

  logic [DATA_W-1:0] up_q;
  logic [DATA_W-1:0] dn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= '0;
      dn_q <= '0;
    end else if (take) begin
      up_q <= up_in;
      dn_q <= dn_in;
    end
  end

  assign up_o = disp_en ? up_q : '0;
  assign dn_o = (disp_en && dual_mode) ? dn_q : '0;

endmodule

// File: rtl/lcd_scan_gen.sv
module lcd_scan_gen
  import lcd_scan_pkg::*;
#(
  parameter int NIB_W  = 10,
  parameter int ROW_W  = 10,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  cfg_nibbles,
  input  logic [ROW_W-1:0]  cfg_rows,
  input  logic              dual_mode,
  input  logic              disp_en,
  input  logic [DATA_W-1:0] pix_up,
  input  logic [DATA_W-1:0] pix_dn,
  output logic              pix_req,
  output logic              shift_clk,
  output logic              latch_clk,
  output logic              flm,
  output logic              ac_out,
  output logic [DATA_W-1:0] lu,
  output logic [DATA_W-1:0] ld
);

  // Named internal events, also watched by the bound checker.
  scan_phase_e      seq_phase;
  logic             line_last;
  logic             line_end;
  logic [ROW_W-1:0] row_idx;
  logic             first_row;
  logic             frame_start;

  lcd_col_seq #(.NIB_W(NIB_W)) u_col (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_nibbles (cfg_nibbles),
    .phase_o     (seq_phase),
    .line_last_o (line_last),
    .line_end_o  (line_end)
  );

  lcd_row_seq #(.ROW_W(ROW_W)) u_row (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_rows      (cfg_rows),
    .line_last     (line_last),
    .line_end      (line_end),
    .row_o         (row_idx),
    .first_row_o   (first_row),
    .frame_start_o (frame_start),
    .ac_o          (ac_out)
  );

  lcd_nib_path #(.DATA_W(DATA_W)) u_nib (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (pix_req),
    .up_in     (pix_up),
    .dn_in     (pix_dn),
    .dual_mode (dual_mode),
    .disp_en   (disp_en),
    .up_o      (lu),
    .dn_o      (ld)
  );

  assign pix_req   = (seq_phase == PH_LOAD);
  assign shift_clk = (seq_phase == PH_SHIFT);
  assign latch_clk = line_end;
  assign flm       = line_end && first_row;

endmodule

// File: rtl/lcd_scan_gen_chk.sv
module lcd_scan_gen_chk
  import lcd_scan_pkg::*;
#(
  parameter int ROW_W  = 10,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ROW_W-1:0]  cfg_rows,
  input logic              dual_mode,
  input logic              disp_en,
  input logic              pix_req,
  input logic              shift_clk,
  input logic              latch_clk,
  input logic              flm,
  input logic              ac_out,
  input logic [DATA_W-1:0] lu,
  input logic [DATA_W-1:0] ld,
  input logic [ROW_W-1:0]  row_idx,
  input logic              frame_start
);

  assert_shift_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_clk |=> !shift_clk);

  assert_latch_after_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    latch_clk |-> ($past(shift_clk) && !shift_clk));

  assert_flm_inside_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flm |-> latch_clk);

  assert_frame_start_flm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> flm);

  assert_row_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(row_idx) < int'(eff_count(32'(cfg_rows))));

  assert_ac_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flm) |-> (ac_out != $past(ac_out)));

  assert_ac_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(flm) |-> $stable(ac_out));

  assert_req_then_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_req |=> shift_clk);

  assert_single_low_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_mode |-> (ld == '0));

  assert_blank_buses_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |-> ((lu == '0) && (ld == '0)));

endmodule

bind lcd_scan_gen lcd_scan_gen_chk #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_rows    (cfg_rows),
  .dual_mode   (dual_mode),
  .disp_en     (disp_en),
  .pix_req     (pix_req),
  .shift_clk   (shift_clk),
  .latch_clk   (latch_clk),
  .flm         (flm),
  .ac_out      (ac_out),
  .lu          (lu),
  .ld          (ld),
  .row_idx     (row_idx),
  .frame_start (frame_start)
);

// File: tb/lcd_scan_gen_test.sv
module lcd_scan_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int NIB_W  = 10;
  localparam int ROW_W  = 10;
  localparam int DATA_W = 4;

  // Stimulus table: nibbles, rows, dual, enable, cycles to run.
  localparam int NV = 6;
  localparam int T_NIB [NV] = '{3, 5, 2, 1, 0, 4};
  localparam int T_ROW [NV] = '{4, 2, 3, 1, 0, 3};
  localparam int T_DUAL[NV] = '{1, 0, 1, 1, 1, 1};
  localparam int T_EN  [NV] = '{1, 1, 0, 1, 1, 1};
  localparam int T_CYC [NV] = '{120, 100, 60, 30, 20, 90};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NIB_W-1:0]  cfg_nibbles = '0;
  logic [ROW_W-1:0]  cfg_rows = '0;
  logic              dual_mode = 1'b0;
  logic              disp_en = 1'b0;
  logic [DATA_W-1:0] pix_up = '0;
  logic [DATA_W-1:0] pix_dn = '0;
  logic              pix_req, shift_clk, latch_clk, flm, ac_out;
  logic [DATA_W-1:0] lu, ld;

  int  tests = 0;
  int  fails = 0;
  bit  finished = 1'b0;

  lcd_scan_gen #(.NIB_W(NIB_W), .ROW_W(ROW_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_nibbles(cfg_nibbles), .cfg_rows(cfg_rows),
    .dual_mode(dual_mode), .disp_en(disp_en), .pix_up(pix_up), .pix_dn(pix_dn),
    .pix_req(pix_req), .shift_clk(shift_clk), .latch_clk(latch_clk), .flm(flm),
    .ac_out(ac_out), .lu(lu), .ld(ld)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Reference for the state after k edges since reset release.
  task automatic compare(input int k, input int nib, input int rows,
                         input bit dual, input bit en);
    int n, r, per, t, row, n2;
    int e_shift, e_latch, e_flm, e_ac, e_req, e_lu, e_ld;
    string tg_shift, tg_frame, tg_lu, tg_ld;
    n   = (nib == 0) ? 1 : nib;
    r   = (rows == 0) ? 1 : rows;
    per = 2 * n + 1;
    n2  = 2 * n;
    t   = k % per;
    row = (k / per) % r;
    e_shift = (t < n2 && (t % 2) == 1) ? 1 : 0;
    e_req   = (t < n2 && (t % 2) == 0) ? 1 : 0;
    e_latch = (t == n2) ? 1 : 0;
    e_flm   = (e_latch == 1 && row == 0) ? 1 : 0;
    e_ac    = (k < n2) ? 0 : (((k - n2) / (per * r)) + 1) % 2;
    e_lu    = (e_shift == 1 && en) ? ((k - 1) & 15) : -1;
    e_ld    = (e_shift == 1 && en && dual) ? (15 - ((k - 1) & 15)) : -1;
    tg_shift = (nib == 0) ? "R10 shift" : "R1 shift";
    tg_frame = (r == 1) ? ((rows == 0) ? "R10 frame" : "R9 frame") : "R3 flm";
    tg_lu    = en ? "R5 lu" : "R7 lu";
    tg_ld    = !en ? "R7 ld" : (dual ? "R6 ld" : "R6 single ld");
    check(tg_shift, int'(shift_clk), e_shift);
    check("R2 latch", int'(latch_clk), e_latch);
    check(tg_frame, int'(flm), e_flm);
    check((r == 1) ? "R9 ac" : "R4 ac", int'(ac_out), e_ac);
    check("R5 req", int'(pix_req), e_req);
    if (!en) begin
      check(tg_lu, int'(lu), 0);
      check(tg_ld, int'(ld), 0);
    end else begin
      if (e_lu >= 0) check(tg_lu, int'(lu), e_lu);
      if (!dual) check(tg_ld, int'(ld), 0);
      else if (e_ld >= 0) check(tg_ld, int'(ld), e_ld);
    end
  endtask

  task automatic reset_check();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8 reset shift", int'(shift_clk), 0);
    check("R8 reset latch", int'(latch_clk), 0);
    check("R8 reset flm", int'(flm), 0);
    check("R8 reset ac", int'(ac_out), 0);
    check("R8 reset lu", int'(lu), 0);
    check("R8 reset ld", int'(ld), 0);
  endtask

  task automatic run_cfg(input int nib, input int rows, input bit dual,
                         input bit en, input int cycles);
    reset_check();
    cfg_nibbles = NIB_W'(nib);
    cfg_rows    = ROW_W'(rows);
    dual_mode   = dual;
    disp_en     = en;
    pix_up      = '0;
    pix_dn      = 4'hF;
    @(negedge clk);
    rst_n = 1'b1;
    compare(0, nib, rows, dual, en);
    for (int k = 1; k <= cycles; k++) begin
      @(negedge clk);
      compare(k, nib, rows, dual, en);
      pix_up = DATA_W'(k);
      pix_dn = ~DATA_W'(k);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      run_cfg(T_NIB[i], T_ROW[i], T_DUAL[i] != 0, T_EN[i] != 0, T_CYC[i]);
    end
    // R8: reset part-way through a frame, with ac_out high and nibbles held.
    run_cfg(3, 4, 1'b1, 1'b1, 10);
    run_cfg(3, 4, 1'b1, 1'b1, 40);
    // R7: blanking in single mode, timing still running.
    run_cfg(2, 2, 1'b0, 1'b0, 30);
    // R1/R3 at a wider line with many rows.
    run_cfg(16, 6, 1'b1, 1'b1, 400);
    reset_check();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule